// File: doc/BRIEF.md
# Fast Multi-Element Program Collector

This block sits between the command write path of a flash controller and its program engine. It collects the write sequences of a fast, multi-element program command. A setup write picks one of five collection modes: two or four 16-bit words, or two, four or eight bytes. The block then latches the following writes as address/data pairs. Each pair goes into a lane of an eight-byte staging buffer, and the lane is chosen by the address bits that may vary within the mode's aligned group.

Every pair after the first must lie in the same aligned group as the first pair. A pair that falls outside it cancels the whole sequence, and no request goes out. When the last pair of the mode arrives, the block issues one program request for the whole group. The request carries the group base address, the 64-bit payload, a per-byte valid mask and a word-mode flag, and it is marked by a one-clock start pulse.

Addresses are byte addresses, and bit 0 is the lowest byte-address bit. Setup writes are refused while the downstream engine reports busy.

Top module: `fmp_collector`

## Requirements
- R1: During and right after reset, `prog_start` is 0, `prog_lanes` is 0, `prog_payload` is 0 and the block is idle.
- R2: In idle, a write whose data bits [7:0] equal 0xA1 selects double word mode. 0xA2 selects quadruple word, 0xB1 double byte, 0xB2 quadruple byte and 0xB3 octuple byte. Any other value is ignored, and the block stays idle.
- R3: A write made while idle and while `eng_busy` is high is ignored, even if it carries a valid setup code.
- R4: After setup, double modes take 2 data writes, quadruple modes 4 and octuple 8. `prog_start` rises in the cycle after the last data write and never earlier.
- R5: The bits that may vary within a group are as follows. Double word: bit 1. Quadruple word: bits 2:1. Double byte: bit 0. Quadruple byte: bits 1:0. Octuple byte: bits 2:0. In word modes, bit 0 is ignored.
- R6: A data write whose address differs from the first pair's address above the mode's group bits cancels the sequence. No request is issued, and the next write is treated as a possible setup.
- R7: In byte modes, `wr_data[7:0]` goes to lane `addr[2:0]` masked to the group bits. In word modes, the word with index i goes to lanes 2i (low byte) and 2i+1 (high byte). `prog_lanes` flags the written lanes. Unwritten lanes read 0, and a repeated address overwrites its earlier data.
- R8: `prog_start` lasts exactly one clock. `prog_base`, `prog_payload`, `prog_lanes` and `prog_word_mode` change only with a new start pulse.
- R9: `prog_base` is the first pair's address with the group bits and bit 0 cleared.
- R10: `prog_word_mode` is 1 for requests from word modes and 0 for requests from byte modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle command write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 16 | Write data; bits [7:0] hold the setup code or byte data |
| eng_busy | input | 1 | Program engine busy; blocks new setups |
| prog_start | output | 1 | One-cycle program request strobe |
| prog_base | output | ADDR_W | Aligned group base address |
| prog_payload | output | 64 | Collected data, byte lane k at bits 8k+7:8k |
| prog_lanes | output | 8 | Per-byte valid flags |
| prog_word_mode | output | 1 | Request came from a word mode |

## Verification
The assertions assume that `wr_en` is a single-cycle strobe per write and that a busy engine only ever blocks setups. They also assume that any sequence reaching its last pair has therefore started with a setup at least two cycles earlier, so start pulses can never be adjacent. The stimulus draws a mode and an aligned base at random. It then places the element addresses randomly inside the group, sometimes repeating one, and sets the bit 0 or the upper data byte to noise where those are ignored. Now and then it corrupts an upper address bit of a later pair to force a cancel. Directed cases cover unknown codes and setups while busy. They also cover each mode's element count and a cancel on the very last pair.

// File: rtl/fmp_pkg.sv
// Package: shared types and constants for the fast multi-element program collector.
// Assumes a fixed eight-byte staging group, which is the widest mode (octuple byte).
package fmp_pkg;

    localparam int GROUP_BYTES = 8;
    localparam int LANE_W      = $clog2(GROUP_BYTES);
    localparam int PAYLOAD_W   = GROUP_BYTES * 8;
    localparam int DATA_W      = 16;
    localparam int CNT_W       = 4;

    // Setup codes carried on wr_data[7:0]
    localparam logic [7:0] CODE_DWORD = 8'hA1;
    localparam logic [7:0] CODE_QWORD = 8'hA2;
    localparam logic [7:0] CODE_DBYTE = 8'hB1;
    localparam logic [7:0] CODE_QBYTE = 8'hB2;
    localparam logic [7:0] CODE_OBYTE = 8'hB3;

    typedef enum logic [2:0] {
        FM_NONE  = 3'd0,
        FM_DWORD = 3'd1,
        FM_QWORD = 3'd2,
        FM_DBYTE = 3'd3,
        FM_QBYTE = 3'd4,
        FM_OBYTE = 3'd5
    } fm_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } fm_state_e;

endpackage

// File: rtl/fmp_decode.sv
// Module: turns a setup data byte into a collection mode.
// Assumes the code arrives on the low data byte; unknown codes yield FM_NONE.
module fmp_decode
    import fmp_pkg::*;
(
    input  logic [7:0] code,
    output fm_mode_e   mode
);

    // Map each recognised setup code to its mode
    always_comb begin
        unique case (code)
            CODE_DWORD: mode = FM_DWORD;
            CODE_QWORD: mode = FM_QWORD;
            CODE_DBYTE: mode = FM_DBYTE;
            CODE_QBYTE: mode = FM_QBYTE;
            CODE_OBYTE: mode = FM_OBYTE;
            default:    mode = FM_NONE;
        endcase
    end

endmodule

// File: rtl/fmp_mode_info.sv
// Module: per-mode attributes (element count, group size in address bits, word flag).
// Assumes byte addressing; span_log counts the low address bits that form the group.
module fmp_mode_info
    import fmp_pkg::*;
(
    input  fm_mode_e         mode,
    output logic [CNT_W-1:0] need_cnt,
    output logic [1:0]       span_log,
    output logic             wide
);

    // Table of count, span and width for each mode
    always_comb begin
        need_cnt = '0;
        span_log = 2'd0;
        wide     = 1'b0;
        unique case (mode)
            FM_DWORD: begin need_cnt = 4'd2; span_log = 2'd2; wide = 1'b1; end
            FM_QWORD: begin need_cnt = 4'd4; span_log = 2'd3; wide = 1'b1; end
            FM_DBYTE: begin need_cnt = 4'd2; span_log = 2'd1; wide = 1'b0; end
            FM_QBYTE: begin need_cnt = 4'd4; span_log = 2'd2; wide = 1'b0; end
            FM_OBYTE: begin need_cnt = 4'd8; span_log = 2'd3; wide = 1'b0; end
            default:  begin need_cnt = '0;   span_log = 2'd0; wide = 1'b0; end
        endcase
    end

endmodule

// File: rtl/fmp_gather.sv
// Module: eight-lane byte staging buffer with valid flags.
// Assumes offset is already masked to the group and has bit 0 cleared in word mode.
// nxt_* show the buffer contents including the write of the current cycle.
module fmp_gather
    import fmp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   we,
    input  logic                   wide,
    input  logic [LANE_W-1:0]      offset,
    input  logic [DATA_W-1:0]      data,
    output logic [PAYLOAD_W-1:0]   nxt_payload,
    output logic [GROUP_BYTES-1:0] nxt_lanes
);

    logic [PAYLOAD_W-1:0]   pay_q;
    logic [GROUP_BYTES-1:0] val_q;

    for (genvar i = 0; i < GROUP_BYTES; i++) begin : g_lane
        localparam logic [LANE_W-1:0] LI = LANE_W'(i);
        logic       hit;
        logic [7:0] bval;

        // Lane select: word writes claim a lane pair, byte writes a single lane
        always_comb begin
            hit  = we && (wide ? (offset[LANE_W-1:1] == LI[LANE_W-1:1]) : (offset == LI));
            bval = (wide && LI[0]) ? data[15:8] : data[7:0];
        end

        // Next contents of this lane
        always_comb begin
            if (clear) begin
                nxt_payload[8*i +: 8] = 8'h00;
                nxt_lanes[i]          = 1'b0;
            end else if (hit) begin
                nxt_payload[8*i +: 8] = bval;
                nxt_lanes[i]          = 1'b1;
            end else begin
                nxt_payload[8*i +: 8] = pay_q[8*i +: 8];
                nxt_lanes[i]          = val_q[i];
            end
        end
    end

    // Store the staged lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_q <= '0;
            val_q <= '0;
        end else begin
            pay_q <= nxt_payload;
            val_q <= nxt_lanes;
        end
    end

endmodule

// File: rtl/fmp_collector.sv
// Module: top of the fast multi-element program collector.
// Accepts a setup write, gathers the mode's address/data pairs within one aligned
// group, and emits a single registered request on the last pair. Assumes wr_en is a
// one-cycle strobe per write and that eng_busy only gates new setups.
module fmp_collector
    import fmp_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   eng_busy,
    output logic                   prog_start,
    output logic [ADDR_W-1:0]      prog_base,
    output logic [PAYLOAD_W-1:0]   prog_payload,
    output logic [GROUP_BYTES-1:0] prog_lanes,
    output logic                   prog_word_mode
);

    fm_state_e              state_q;
    fm_mode_e               mode_q;
    fm_mode_e               dec_mode;
    logic [CNT_W-1:0]       taken_q;
    logic [ADDR_W-1:0]      base_q;
    logic [CNT_W-1:0]       need_cnt;
    logic [1:0]             span_log;
    logic                   wide;
    logic [ADDR_W-1:0]      grp_mask;
    logic [ADDR_W-1:0]      wr_base;
    logic [LANE_W-1:0]      offset;
    logic                   first_elem;
    logic                   tag_ok;
    logic                   collecting;
    logic                   setup_ok;
    logic                   data_wr;
    logic                   abort;
    logic                   last;
    logic [PAYLOAD_W-1:0]   nxt_payload;
    logic [GROUP_BYTES-1:0] nxt_lanes;

    fmp_decode u_decode (
        .code (wr_data[7:0]),
        .mode (dec_mode)
    );

    fmp_mode_info u_info (
        .mode     (mode_q),
        .need_cnt (need_cnt),
        .span_log (span_log),
        .wide     (wide)
    );

    // Group tag and lane offset of the incoming write
    always_comb begin
        grp_mask   = {ADDR_W{1'b1}} << span_log;
        wr_base    = wr_addr & grp_mask;
        offset     = wr_addr[LANE_W-1:0] & ~(3'b111 << span_log) & (wide ? 3'b110 : 3'b111);
        first_elem = (taken_q == '0);
        tag_ok     = first_elem || (wr_base == base_q);
    end

    // Classify the write against the current state
    always_comb begin
        collecting = (state_q == ST_COLLECT);
        setup_ok   = !collecting && wr_en && !eng_busy && (dec_mode != FM_NONE);
        data_wr    = collecting && wr_en && tag_ok;
        abort      = collecting && wr_en && !tag_ok;
        last       = data_wr && ((taken_q + 4'd1) == need_cnt);
    end

    fmp_gather u_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (setup_ok),
        .we          (data_wr),
        .wide        (wide),
        .offset      (offset),
        .data        (wr_data),
        .nxt_payload (nxt_payload),
        .nxt_lanes   (nxt_lanes)
    );

    // Sequence control: setup, element counting, cancel and commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= FM_NONE;
            taken_q <= '0;
            base_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (setup_ok) begin
                        state_q <= ST_COLLECT;
                        mode_q  <= dec_mode;
                        taken_q <= '0;
                    end
                end
                ST_COLLECT: begin
                    if (abort) begin
                        state_q <= ST_IDLE;
                    end else if (data_wr) begin
                        taken_q <= taken_q + 4'd1;
                        if (first_elem) base_q <= wr_base;
                        if (last) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request register: loaded only on commit, strobe lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_start     <= 1'b0;
            prog_base      <= '0;
            prog_payload   <= '0;
            prog_lanes     <= '0;
            prog_word_mode <= 1'b0;
        end else begin
            prog_start <= last;
            if (last) begin
                prog_base      <= base_q;
                prog_payload   <= nxt_payload;
                prog_lanes     <= nxt_lanes;
                prog_word_mode <= wide;
            end
        end
    end

endmodule

// File: rtl/fmp_collector_chk.sv
// Checker: temporal properties of the collector, attached by bind.
// Assumes wr_en pulses mark individual writes and reset is synchronous active-low.
module fmp_collector_chk
    import fmp_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   eng_busy,
    input logic                   collecting,
    input logic                   prog_start,
    input logic [ADDR_W-1:0]      prog_base,
    input logic [PAYLOAD_W-1:0]   prog_payload,
    input logic [GROUP_BYTES-1:0] prog_lanes,
    input logic                   prog_word_mode
);

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_start |-> ($stable(prog_base) && $stable(prog_payload) && $stable(prog_lanes)
                         && $stable(prog_word_mode)));

    assert_commit_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> ($past(wr_en) && !collecting));

    assert_busy_blocks_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!collecting && wr_en && eng_busy) |=> !collecting);

    assert_lanes_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (prog_lanes != '0));

    assert_word_pairs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && prog_word_mode) |->
            (prog_lanes[0] == prog_lanes[1] && prog_lanes[2] == prog_lanes[3] &&
             prog_lanes[4] == prog_lanes[5] && prog_lanes[6] == prog_lanes[7]));

endmodule

bind fmp_collector fmp_collector_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .eng_busy       (eng_busy),
    .collecting     (collecting),
    .prog_start     (prog_start),
    .prog_base      (prog_base),
    .prog_payload   (prog_payload),
    .prog_lanes     (prog_lanes),
    .prog_word_mode (prog_word_mode)
);

// File: tb/fmp_collector_tb.sv
module fmp_collector_tb;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          eng_busy = 1'b0;
    logic          prog_start;
    logic [AW-1:0] prog_base;
    logic [63:0]   prog_payload;
    logic [7:0]    prog_lanes;
    logic          prog_word_mode;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    fmp_collector #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eng_busy(eng_busy), .prog_start(prog_start), .prog_base(prog_base),
        .prog_payload(prog_payload), .prog_lanes(prog_lanes), .prog_word_mode(prog_word_mode)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Mode table from R2/R4/R5: index 0..4 = dword, qword, dbyte, qbyte, obyte
    function automatic logic [7:0] code_of(int m);
        case (m) 0: return 8'hA1; 1: return 8'hA2; 2: return 8'hB1; 3: return 8'hB2; default: return 8'hB3; endcase
    endfunction
    function automatic int count_of(int m);
        case (m) 0, 2: return 2; 1, 3: return 4; default: return 8; endcase
    endfunction
    function automatic int span_of(int m);
        case (m) 0: return 2; 1: return 3; 2: return 1; 3: return 2; default: return 3; endcase
    endfunction
    function automatic bit wide_of(int m);
        return (m < 2);
    endfunction

    task automatic put(logic [AW-1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One complete or cancelled sequence; bad_at > 0 corrupts that pair (R6)
    task automatic run_seq(int m, int bad_at, bit dup);
        int            n    = count_of(m);
        int            sp   = span_of(m);
        bit            w    = wide_of(m);
        logic [AW-1:0] base = AW'($urandom) & ({AW{1'b1}} << sp);
        logic [63:0]   epay = '0;
        logic [7:0]    elan = '0;
        logic [AW-1:0] prev = base;
        put(AW'($urandom), {8'($urandom), code_of(m)});
        check("R2 setup no start", {63'd0, prog_start}, 64'd0);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] a;
            logic [15:0]   d = 16'($urandom);
            int            off;
            a = base | (AW'($urandom) & ~({AW{1'b1}} << sp));
            if (dup && k == n - 1) a = prev;
            prev = a;
            if (k == bad_at && k > 0) a = a ^ (AW'(1) << (sp + ($urandom % 5)));
            put(a, d);
            if (k == bad_at && k > 0) begin
                check("R6 cancel no start", {63'd0, prog_start}, 64'd0);
                @(negedge clk);
                check("R6 cancel no late start", {63'd0, prog_start}, 64'd0);
                return;
            end
            off = int'(a[2:0]) & ((1 << sp) - 1);
            if (w) begin
                off = off & 6;
                epay[8*off +: 16] = d;
                elan[off +: 2]    = 2'b11;
            end else begin
                epay[8*off +: 8] = d[7:0];
                elan[off]        = 1'b1;
            end
            if (k < n - 1) check("R4 no early start", {63'd0, prog_start}, 64'd0);
        end
        check("R4 start after last pair", {63'd0, prog_start}, 64'd1);
        check("R9 base", 64'(prog_base), 64'(base));
        check("R7 payload", prog_payload, epay);
        check("R7 lanes", 64'(prog_lanes), 64'(elan));
        check("R10 word flag", {63'd0, prog_word_mode}, {63'd0, w});
        @(negedge clk);
        check("R8 single pulse", {63'd0, prog_start}, 64'd0);
        check("R8 payload held", prog_payload, epay);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (2) @(negedge clk);
        check("R1 start in reset", {63'd0, prog_start}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 start after reset", {63'd0, prog_start}, 64'd0);
        check("R1 lanes after reset", 64'(prog_lanes), 64'd0);
        check("R1 payload after reset", prog_payload, 64'd0);

        // R2: unknown code then stray writes stay idle
        put(24'h000100, 16'h00C7);
        put(24'h000100, 16'h0011);
        put(24'h000101, 16'h0022);
        check("R2 unknown code ignored", {63'd0, prog_start}, 64'd0);

        // R3: setup while busy, then stray writes stay idle
        eng_busy = 1'b1;
        put(24'h000200, 16'h00B1);
        eng_busy = 1'b0;
        put(24'h000200, 16'h0000);
        put(24'h000201, 16'h0000);
        check("R3 busy setup ignored", {63'd0, prog_start}, 64'd0);

        // Directed: every mode once, cancel on last pair, repeated address
        for (int m = 0; m < 5; m++) run_seq(m, 0, 1'b0);
        run_seq(4, 7, 1'b0);
        run_seq(1, 3, 1'b0);
        run_seq(3, 0, 1'b1);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int m   = int'($urandom % 5);
            int bad = (($urandom % 6) == 0) ? 1 + int'($urandom % (count_of(m) - 1)) : 0;
            run_seq(m, bad, ($urandom % 8) == 0);
            repeat ($urandom % 3) @(negedge clk);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule